// File: doc/BRIEF.md
# Framebuffer Scanout Fetch Sequencer

This block produces the memory read requests that pull one frame of pixels out of a linear framebuffer for a display pipeline. When a frame-start pulse arrives while the block is idle, it captures the frame settings: the byte address of the first visible pixel, the number of bytes to read on each line, the number of lines minus one, and the byte distance from the start of one line to the start of the next. The stride is separate from the line length, so a frame can sit inside a wider surface. The block then works through the frame one line at a time. It cuts each line into fixed-size bursts and sends them over a valid/grant request channel.

Returned beats are written into a downstream pixel FIFO one cycle after they arrive. The block keeps a count of beats it has asked for but not yet written. It only starts a new burst when the FIFO has room for a full burst on top of that count, and when the number of bursts awaiting data is below a limit. It gives a one-cycle pulse once the last burst of the frame has been granted, and a one-cycle pulse for every returned beat that is flagged as a bus error. The settings are captured only at frame start, so software can reprogram the next frame's base address at any time without tearing the current frame.

Top module: `scan_fetch`

## Requirements
- R1: After reset the outputs are quiet: `req_valid`, `fifo_wr`, `fetch_busy`, `fetch_done` and `bus_err` are all 0.
- R2: A `frame_start` pulse while idle captures the four settings and raises `fetch_busy` on the next cycle. A `frame_start` pulse or any change to the settings while busy has no effect on the frame in progress.
- R3: Line k (counting from 0) starts at base + k*pitch. Within a line, each burst address equals the previous burst address plus the previous burst's beat count times the beat size in bytes (DATA_W/8).
- R4: Each burst carries BURST_BEATS beats, except that a line whose beat count is not a multiple of BURST_BEATS ends with one shorter burst holding exactly the remaining beats. The line length in bytes is rounded up to whole beats, so a partial beat is fetched in full.
- R5: A frame fetches exactly `cfg_line_last` + 1 lines.
- R6: Once `req_valid` is raised, it stays high with `req_addr` and `req_beats` unchanged until a cycle in which `req_grant` is high. That cycle completes the transfer.
- R7: At most MAX_OUT bursts are outstanding. A burst counts as outstanding from its grant until the cycle that carries `resp_last` for it.
- R8: A new request is raised only if, in the cycle before, `fifo_space` was at least the number of granted-but-unwritten beats plus BURST_BEATS.
- R9: Every beat with `resp_valid` high appears on `fifo_wr`/`fifo_data` exactly one cycle later, and `fifo_wr` is never high at any other time.
- R10: `bus_err` pulses exactly one cycle after a beat with `resp_valid` and `resp_err` both high, and is 0 otherwise.
- R11: `fetch_done` is high for one cycle, in the cycle after the grant of the last burst of the frame. `fetch_busy` is already 0 in that cycle.
- R12: A line length of zero bytes issues no requests. The frame still ends with `fetch_done` after one cycle per line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Starts a frame fetch when idle |
| cfg_base | input | ADDR_W | Byte address of the first pixel of the frame |
| cfg_line_bytes | input | LINE_W | Bytes to read per line |
| cfg_line_last | input | CNT_W | Number of lines minus one |
| cfg_pitch | input | ADDR_W | Byte distance between consecutive line starts |
| req_valid | output | 1 | Burst read request pending |
| req_addr | output | ADDR_W | Byte address of the requested burst |
| req_beats | output | clog2(BURST_BEATS+1) | Beats in the requested burst |
| req_grant | input | 1 | Request accepted in this cycle |
| resp_valid | input | 1 | Returned data beat present |
| resp_data | input | DATA_W | Returned beat data |
| resp_last | input | 1 | Final beat of a burst |
| resp_err | input | 1 | Returned beat carries a bus error |
| fifo_space | input | SPACE_W | Free entries in the pixel FIFO, current as of this cycle |
| fifo_wr | output | 1 | Write strobe into the pixel FIFO |
| fifo_data | output | DATA_W | Data written into the pixel FIFO |
| fetch_busy | output | 1 | A frame fetch is in progress |
| fetch_done | output | 1 | Pulse: last burst of the frame granted |
| bus_err | output | 1 | Pulse: a returned beat reported an error |

## Verification
The bench builds the block with 4-beat bursts of 32-bit beats, at most two bursts outstanding, and a 12-entry FIFO model. These values make every branch of the burst splitter reachable in lines of only a few words. The bench sweeps every even line length from 0 to 36 bytes with one to three lines and two strides. That range covers empty lines, partial beats, lines that end on a burst boundary and lines that end with a short tail. Random grants, random response gaps and a slow-drain mode push the outstanding limit and the FIFO room rule into their blocking states. Injected bus errors and mid-frame rewrites of the settings show that the frame-start capture and the error pulse work.

// File: rtl/scan_pkg.sv
package scan_pkg;

    // Default geometry shared by the sequencer blocks
    localparam int DEF_ADDR_W      = 32;
    localparam int DEF_DATA_W      = 64;
    localparam int DEF_LINE_W      = 16;
    localparam int DEF_CNT_W       = 12;
    localparam int DEF_BURST_BEATS = 16;
    localparam int DEF_MAX_OUT     = 4;
    localparam int DEF_SPACE_W     = 8;

    // Walker phases
    typedef enum logic [0:0] {
        WALK_IDLE = 1'b0,
        WALK_LINE = 1'b1
    } walk_e;

    // Size of the next burst: whatever is left, capped at the burst limit
    function automatic int unsigned clip_beats(input int unsigned left,
                                               input int unsigned cap);
        return (left < cap) ? left : cap;
    endfunction

    // Beats needed for a byte count, a partial beat rounded up
    function automatic int unsigned beats_for_bytes(input int unsigned nbytes,
                                                    input int unsigned beat_bytes);
        return (nbytes + beat_bytes - 1) / beat_bytes;
    endfunction

endpackage

// File: rtl/scan_walker.sv
module scan_walker
    import scan_pkg::*;
#(
    parameter int ADDR_W      = DEF_ADDR_W,
    parameter int LINE_W      = DEF_LINE_W,
    parameter int CNT_W       = DEF_CNT_W,
    parameter int BEAT_BYTES  = DEF_DATA_W / 8,
    parameter int BURST_BEATS = DEF_BURST_BEATS,
    localparam int LEN_W      = $clog2(BURST_BEATS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [LINE_W-1:0] cfg_line_bytes,
    input  logic [CNT_W-1:0]  cfg_line_last,
    input  logic [ADDR_W-1:0] cfg_pitch,
    input  logic              issue_ok,
    input  logic              req_grant,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LEN_W-1:0]  req_beats,
    output logic              fire,
    output logic              busy,
    output logic              done
);

    localparam int BEAT_SH = $clog2(BEAT_BYTES);
    localparam int LBEAT_W = LINE_W + 1 - BEAT_SH;

    typedef struct packed {
        walk_e              st;
        logic [ADDR_W-1:0]  line_addr;
        logic [ADDR_W-1:0]  burst_addr;
        logic [LBEAT_W-1:0] beats_left;
        logic [CNT_W-1:0]   lines_left;
    } walk_t;

    typedef struct packed {
        logic [ADDR_W-1:0]  pitch;
        logic [LBEAT_W-1:0] beats;
    } frame_cfg_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  beats;
    } burst_req_t;

    walk_t      w_q, w_n;
    frame_cfg_t c_q, c_n;
    burst_req_t r_q, r_n;
    logic       done_q, done_n;

    logic [LBEAT_W-1:0] line_beats;
    logic [LBEAT_W-1:0] beats_after;
    logic [LEN_W-1:0]   cur_beats;
    logic               step;

    assign line_beats = LBEAT_W'(beats_for_bytes(32'(cfg_line_bytes), BEAT_BYTES));
    assign cur_beats  = LEN_W'(clip_beats(32'(w_q.beats_left), BURST_BEATS));

    assign fire        = r_q.valid & req_grant;
    assign beats_after = w_q.beats_left - (fire ? LBEAT_W'(r_q.beats) : '0);
    assign step        = fire || (w_q.beats_left == '0);

    always_comb begin
        w_n    = w_q;
        c_n    = c_q;
        r_n    = r_q;
        done_n = 1'b0;
        unique case (w_q.st)
            WALK_IDLE: begin
                if (frame_start) begin
                    c_n.pitch      = cfg_pitch;
                    c_n.beats      = line_beats;
                    w_n.st         = WALK_LINE;
                    w_n.line_addr  = cfg_base;
                    w_n.burst_addr = cfg_base;
                    w_n.beats_left = line_beats;
                    w_n.lines_left = cfg_line_last;
                end
            end
            WALK_LINE: begin
                if (fire) begin
                    r_n.valid = 1'b0;
                end
                if (step) begin
                    if (beats_after == '0) begin
                        if (w_q.lines_left == '0) begin
                            w_n.st = WALK_IDLE;
                            done_n = 1'b1;
                        end else begin
                            w_n.lines_left = w_q.lines_left - 1'b1;
                            w_n.line_addr  = w_q.line_addr + c_q.pitch;
                            w_n.burst_addr = w_q.line_addr + c_q.pitch;
                            w_n.beats_left = c_q.beats;
                        end
                    end else begin
                        w_n.burst_addr = w_q.burst_addr + (ADDR_W'(r_q.beats) << BEAT_SH);
                        w_n.beats_left = beats_after;
                    end
                end else if (!r_q.valid && issue_ok) begin
                    r_n.valid = 1'b1;
                    r_n.addr  = w_q.burst_addr;
                    r_n.beats = cur_beats;
                end
            end
            default: w_n.st = WALK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            w_q    <= '0;
            c_q    <= '0;
            r_q    <= '0;
            done_q <= 1'b0;
        end else begin
            w_q    <= w_n;
            c_q    <= c_n;
            r_q    <= r_n;
            done_q <= done_n;
        end
    end

    assign req_valid = r_q.valid;
    assign req_addr  = r_q.addr;
    assign req_beats = r_q.beats;
    assign busy      = (w_q.st != WALK_IDLE);
    assign done      = done_q;

endmodule

// File: rtl/scan_credit.sv
module scan_credit
    import scan_pkg::*;
#(
    parameter int BURST_BEATS = DEF_BURST_BEATS,
    parameter int MAX_OUT     = DEF_MAX_OUT,
    parameter int SPACE_W     = DEF_SPACE_W,
    localparam int LEN_W      = $clog2(BURST_BEATS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fire,
    input  logic [LEN_W-1:0]   fire_beats,
    input  logic               beat_written,
    input  logic               burst_closed,
    input  logic [SPACE_W-1:0] fifo_space,
    output logic               issue_ok
);

    localparam int IF_W  = $clog2(MAX_OUT * BURST_BEATS + 1);
    localparam int OUT_W = $clog2(MAX_OUT + 1);
    localparam int CMP_W = ((IF_W > SPACE_W) ? IF_W : SPACE_W) + 1;

    logic [IF_W-1:0]  inflight_q;
    logic [OUT_W-1:0] open_q;
    logic             room_ok;
    logic             slot_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            inflight_q <= '0;
            open_q     <= '0;
        end else begin
            inflight_q <= inflight_q
                        + (fire ? IF_W'(fire_beats) : '0)
                        - (beat_written ? IF_W'(1) : '0);
            open_q     <= open_q
                        + (fire ? OUT_W'(1) : '0)
                        - (burst_closed ? OUT_W'(1) : '0);
        end
    end

    assign room_ok  = CMP_W'(fifo_space) >= (CMP_W'(inflight_q) + CMP_W'(BURST_BEATS));
    assign slot_ok  = open_q < OUT_W'(MAX_OUT);
    assign issue_ok = room_ok && slot_ok;

endmodule

// File: rtl/scan_return.sv
module scan_return
    import scan_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              resp_valid,
    input  logic [DATA_W-1:0] resp_data,
    input  logic              resp_err,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_data,
    output logic              bus_err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_wr   <= 1'b0;
            fifo_data <= '0;
            bus_err   <= 1'b0;
        end else begin
            fifo_wr   <= resp_valid;
            fifo_data <= resp_data;
            bus_err   <= resp_valid & resp_err;
        end
    end

endmodule

// File: rtl/scan_fetch.sv
module scan_fetch
    import scan_pkg::*;
#(
    parameter int ADDR_W      = DEF_ADDR_W,
    parameter int DATA_W      = DEF_DATA_W,
    parameter int LINE_W      = DEF_LINE_W,
    parameter int CNT_W       = DEF_CNT_W,
    parameter int BURST_BEATS = DEF_BURST_BEATS,
    parameter int MAX_OUT     = DEF_MAX_OUT,
    parameter int SPACE_W     = DEF_SPACE_W,
    localparam int LEN_W      = $clog2(BURST_BEATS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_start,
    input  logic [ADDR_W-1:0]  cfg_base,
    input  logic [LINE_W-1:0]  cfg_line_bytes,
    input  logic [CNT_W-1:0]   cfg_line_last,
    input  logic [ADDR_W-1:0]  cfg_pitch,
    output logic               req_valid,
    output logic [ADDR_W-1:0]  req_addr,
    output logic [LEN_W-1:0]   req_beats,
    input  logic               req_grant,
    input  logic               resp_valid,
    input  logic [DATA_W-1:0]  resp_data,
    input  logic               resp_last,
    input  logic               resp_err,
    input  logic [SPACE_W-1:0] fifo_space,
    output logic               fifo_wr,
    output logic [DATA_W-1:0]  fifo_data,
    output logic               fetch_busy,
    output logic               fetch_done,
    output logic               bus_err
);

    localparam int BEAT_BYTES = DATA_W / 8;

    logic issue_ok;
    logic fire;

    scan_walker #(
        .ADDR_W      (ADDR_W),
        .LINE_W      (LINE_W),
        .CNT_W       (CNT_W),
        .BEAT_BYTES  (BEAT_BYTES),
        .BURST_BEATS (BURST_BEATS)
    ) u_walker (
        .clk            (clk),
        .rst            (rst),
        .frame_start    (frame_start),
        .cfg_base       (cfg_base),
        .cfg_line_bytes (cfg_line_bytes),
        .cfg_line_last  (cfg_line_last),
        .cfg_pitch      (cfg_pitch),
        .issue_ok       (issue_ok),
        .req_grant      (req_grant),
        .req_valid      (req_valid),
        .req_addr       (req_addr),
        .req_beats      (req_beats),
        .fire           (fire),
        .busy           (fetch_busy),
        .done           (fetch_done)
    );

    scan_credit #(
        .BURST_BEATS (BURST_BEATS),
        .MAX_OUT     (MAX_OUT),
        .SPACE_W     (SPACE_W)
    ) u_credit (
        .clk          (clk),
        .rst          (rst),
        .fire         (fire),
        .fire_beats   (req_beats),
        .beat_written (fifo_wr),
        .burst_closed (resp_valid & resp_last),
        .fifo_space   (fifo_space),
        .issue_ok     (issue_ok)
    );

    scan_return #(
        .DATA_W (DATA_W)
    ) u_return (
        .clk        (clk),
        .rst        (rst),
        .resp_valid (resp_valid),
        .resp_data  (resp_data),
        .resp_err   (resp_err),
        .fifo_wr    (fifo_wr),
        .fifo_data  (fifo_data),
        .bus_err    (bus_err)
    );

endmodule

// File: rtl/scan_fetch_chk.sv
module scan_fetch_chk #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 64,
    parameter int BURST_BEATS = 16,
    parameter int MAX_OUT     = 4,
    parameter int SPACE_W     = 8,
    localparam int LEN_W      = $clog2(BURST_BEATS + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               frame_start,
    input logic               req_valid,
    input logic [ADDR_W-1:0]  req_addr,
    input logic [LEN_W-1:0]   req_beats,
    input logic               req_grant,
    input logic               resp_valid,
    input logic [DATA_W-1:0]  resp_data,
    input logic               resp_last,
    input logic               resp_err,
    input logic [SPACE_W-1:0] fifo_space,
    input logic               fifo_wr,
    input logic [DATA_W-1:0]  fifo_data,
    input logic               fetch_busy,
    input logic               fetch_done,
    input logic               bus_err
);

    // Independent bookkeeping from the port activity
    int  seen_open;
    int  seen_inflight;
    logic room_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_open     <= 0;
            seen_inflight <= 0;
            room_seen     <= 1'b0;
        end else begin
            seen_open     <= seen_open + ((req_valid && req_grant) ? 1 : 0)
                           - ((resp_valid && resp_last) ? 1 : 0);
            seen_inflight <= seen_inflight + ((req_valid && req_grant) ? int'(req_beats) : 0)
                           - (fifo_wr ? 1 : 0);
            room_seen     <= (int'(fifo_space) >= seen_inflight + BURST_BEATS);
        end
    end

    a_r2_busy_start: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !fetch_busy) |=> fetch_busy);

    a_r4_beats_range: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_beats != '0) && (int'(req_beats) <= BURST_BEATS));

    a_r6_req_hold: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_grant) |=> (req_valid && $stable(req_addr) && $stable(req_beats)));

    a_r7_open_cap: assert property (@(posedge clk) disable iff (rst)
        seen_open <= MAX_OUT);

    a_r8_room: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid) |-> room_seen);

    a_r9_fifo_copy: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> (fifo_wr && fifo_data == $past(resp_data)));

    a_r9_fifo_quiet: assert property (@(posedge clk) disable iff (rst)
        !resp_valid |=> !fifo_wr);

    a_r10_err_pulse: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_err) |=> bus_err);

    a_r10_err_quiet: assert property (@(posedge clk) disable iff (rst)
        !(resp_valid && resp_err) |=> !bus_err);

    a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
        fetch_done |-> (!fetch_busy && !req_valid));

    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        fetch_done |=> !fetch_done);

endmodule

bind scan_fetch scan_fetch_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .BURST_BEATS (BURST_BEATS),
    .MAX_OUT     (MAX_OUT),
    .SPACE_W     (SPACE_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_beats   (req_beats),
    .req_grant   (req_grant),
    .resp_valid  (resp_valid),
    .resp_data   (resp_data),
    .resp_last   (resp_last),
    .resp_err    (resp_err),
    .fifo_space  (fifo_space),
    .fifo_wr     (fifo_wr),
    .fifo_data   (fifo_data),
    .fetch_busy  (fetch_busy),
    .fetch_done  (fetch_done),
    .bus_err     (bus_err)
);

// File: tb/sim_scan_fetch.sv
module sim_scan_fetch;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int LW    = 16;
    localparam int CW    = 12;
    localparam int BURST = 4;
    localparam int MAXO  = 2;
    localparam int SW    = 5;
    localparam int DEPTH = 12;
    localparam int BB    = DW / 8;
    localparam int LENW  = $clog2(BURST + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frame_start = 1'b0;
    logic [AW-1:0] cfg_base = '0;
    logic [LW-1:0] cfg_line_bytes = '0;
    logic [CW-1:0] cfg_line_last = '0;
    logic [AW-1:0] cfg_pitch = '0;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic [LENW-1:0] req_beats;
    logic          req_grant = 1'b0;
    logic          resp_valid = 1'b0;
    logic [DW-1:0] resp_data = '0;
    logic          resp_last = 1'b0;
    logic          resp_err = 1'b0;
    logic [SW-1:0] fifo_space;
    logic          fifo_wr;
    logic [DW-1:0] fifo_data;
    logic          fetch_busy;
    logic          fetch_done;
    logic          bus_err;

    always #(CLK_PERIOD / 2) clk = ~clk;

    scan_fetch #(
        .ADDR_W(AW), .DATA_W(DW), .LINE_W(LW), .CNT_W(CW),
        .BURST_BEATS(BURST), .MAX_OUT(MAXO), .SPACE_W(SW)
    ) u0 (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .cfg_base(cfg_base), .cfg_line_bytes(cfg_line_bytes),
        .cfg_line_last(cfg_line_last), .cfg_pitch(cfg_pitch),
        .req_valid(req_valid), .req_addr(req_addr), .req_beats(req_beats),
        .req_grant(req_grant), .resp_valid(resp_valid), .resp_data(resp_data),
        .resp_last(resp_last), .resp_err(resp_err), .fifo_space(fifo_space),
        .fifo_wr(fifo_wr), .fifo_data(fifo_data), .fetch_busy(fetch_busy),
        .fetch_done(fetch_done), .bus_err(bus_err)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Pixel FIFO model
    int   fcnt = 0;
    logic drain = 1'b0;
    always @(posedge clk) begin
        if (rst) fcnt <= 0;
        else     fcnt <= fcnt + (fifo_wr ? 1 : 0) - ((drain && fcnt > 0) ? 1 : 0);
    end
    assign fifo_space = SW'(DEPTH - fcnt);

    // Expected request and data sequences
    logic [AW-1:0] ea [0:63];
    int            eb [0:63];
    logic [DW-1:0] ed [0:127];
    int n_exp = 0, idx = 0, n_data = 0, dcnt = 0, done_seen = 0;
    bit err_en = 0, slow_drain = 0, zero_mode = 0;

    // Responder queue and tracking
    logic [AW-1:0] rq_a [0:7];
    int            rq_b [0:7];
    int qh = 0, qt = 0, rbeat = 0;
    int infl = 0, outst = 0;
    bit last_prev = 0, err_prev = 0, room_prev = 0, valid_prev = 0;
    logic [15:0] lf = 16'hACE1;

    always @(negedge clk) begin
        if (!rst) begin
            if (fifo_wr) begin
                chk(dcnt < n_data && fifo_data == ed[dcnt < 128 ? dcnt : 0], "R9", "fifo data",
                    fifo_data, (dcnt < n_data) ? ed[dcnt] : 0);
                chk(fcnt < DEPTH, "R8", "fifo fill before write", fcnt, DEPTH - 1);
                dcnt++;
            end
            if (bus_err || err_prev)
                chk(bus_err == err_prev, "R10", "bus error pulse", bus_err, err_prev);
            if (fetch_done) begin
                done_seen++;
                chk(!fetch_busy, "R11", "busy with done", fetch_busy, 0);
            end
            if (!zero_mode && (fetch_done || last_prev))
                chk(fetch_done == last_prev, "R11", "done timing", fetch_done, last_prev);
            if (req_valid && !valid_prev)
                chk(room_prev, "R8", "room before request", room_prev, 1);
            room_prev  = (int'(fifo_space) >= infl + BURST) && (outst < MAXO);
            valid_prev = req_valid;

            // Response beat for this cycle
            err_prev = 0;
            if (qh != qt && (lf[1] | lf[6])) begin
                resp_valid = 1'b1;
                resp_data  = DW'(rq_a[qh % 8] + AW'(rbeat * BB));
                resp_last  = (rbeat == rq_b[qh % 8] - 1);
                resp_err   = err_en && (rbeat == 1);
                err_prev   = resp_err;
                if (resp_last) begin
                    rbeat = 0;
                    qh++;
                    outst--;
                end else begin
                    rbeat++;
                end
            end else begin
                resp_valid = 1'b0;
                resp_last  = 1'b0;
                resp_err   = 1'b0;
            end

            // Grant decision for the coming edge
            last_prev = 0;
            req_grant = 1'b0;
            if (req_valid && (lf[0] | lf[5])) begin
                req_grant = 1'b1;
                chk(idx < n_exp && req_addr == ea[idx < 64 ? idx : 0], (n_exp == 0) ? "R12" : "R3",
                    "burst address", req_addr, (idx < n_exp) ? ea[idx] : 0);
                chk(idx < n_exp && int'(req_beats) == eb[idx < 64 ? idx : 0], "R4", "burst beats",
                    req_beats, (idx < n_exp) ? eb[idx] : 0);
                chk(outst < MAXO, "R7", "open bursts before grant", outst, MAXO - 1);
                rq_a[qt % 8] = req_addr;
                rq_b[qt % 8] = int'(req_beats);
                qt++;
                infl  += int'(req_beats);
                outst++;
                if (idx == n_exp - 1) last_prev = 1;
                idx++;
            end
            if (fifo_wr) infl--;

            drain = slow_drain ? (lf[2] & lf[3]) : (lf[2] | lf[3]);
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        end
    end

    task automatic run_frame(input int base, input int lb, input int last,
                             input int pitch, input bit errs, input bit slow);
        int beats_line;
        int t;
        beats_line = (lb + BB - 1) / BB;
        n_exp  = 0;
        n_data = 0;
        for (int l = 0; l <= last; l++) begin
            int a;
            int rem;
            a   = base + l * pitch;
            rem = beats_line;
            while (rem > 0) begin
                int b;
                b = (rem > BURST) ? BURST : rem;
                ea[n_exp] = AW'(a);
                eb[n_exp] = b;
                n_exp++;
                for (int k = 0; k < b; k++) begin
                    ed[n_data] = DW'(a + k * BB);
                    n_data++;
                end
                a   += b * BB;
                rem -= b;
            end
        end
        idx = 0; dcnt = 0; done_seen = 0;
        err_en = errs; slow_drain = slow; zero_mode = (lb == 0);

        @(negedge clk);
        cfg_base       = AW'(base);
        cfg_line_bytes = LW'(lb);
        cfg_line_last  = CW'(last);
        cfg_pitch      = AW'(pitch);
        frame_start    = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        chk(fetch_busy == 1'b1, "R2", "busy after start", fetch_busy, 1);
        // Rewrite every setting mid-frame; the running frame must not notice
        cfg_base       = 32'h00F0_0000;
        cfg_line_bytes = LW'(100);
        cfg_line_last  = CW'(7);
        cfg_pitch      = 32'h40;
        if (lb >= 8) begin
            frame_start = 1'b1;
            @(negedge clk);
            frame_start = 1'b0;
        end
        t = 0;
        while (!(done_seen > 0 && dcnt == n_data && qh == qt) && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk(done_seen == 1, "R11", "done pulses per frame", done_seen, 1);
        chk(idx == n_exp, (lb == 0) ? "R12" : "R5", "bursts per frame", idx, n_exp);
        chk(dcnt == n_data, "R2", "beats per frame", dcnt, n_data);
        repeat (3) @(negedge clk);
        chk(!fetch_busy && !req_valid, "R2", "idle after frame", fetch_busy, 0);
    endtask

    bit finished = 0;

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!req_valid, "R1", "req_valid after reset", req_valid, 0);
        chk(!fifo_wr, "R1", "fifo_wr after reset", fifo_wr, 0);
        chk(!fetch_busy, "R1", "busy after reset", fetch_busy, 0);
        chk(!fetch_done && !bus_err, "R1", "pulses after reset", fetch_done | bus_err, 0);

        for (int lb = 0; lb <= 36; lb += 2) begin
            for (int last = 0; last <= 2; last++) begin
                for (int pv = 0; pv < 2; pv++) begin
                    run_frame(32'h1000 + lb * 32'h100 + pv * 32'h10000,
                              lb, last, (pv == 0) ? 64 : 200,
                              (lb % 4) == 2, last == 2);
                end
            end
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule